// File: doc/BRIEF.md
# Integer ALU with Fused Word Shift-Add

This block is the integer arithmetic unit of a 64-bit execute stage. It is purely combinational, holds no state and produces its result in the same cycle that the operator and operands arrive. A 4-bit operator code selects one of the following operations:

- add and subtract, in full-width and 32-bit word forms;
- signed and unsigned less-than compares;
- left, logical right and arithmetic right shifts, in full-width and word forms.

One further opcode fuses two steps into one. It shifts the low word of operand A right logically by a fixed 31 positions, with no shift-amount input. It then adds that value to operand B as a word operation. The result goes back to the register that supplied operand B, which makes the step a one-instruction accumulate of a single carry-out bit.

A thin valid/ready wrapper lets the unit sit in a pipeline next to multi-cycle units. Because the unit never stalls, ready is always asserted and the output valid follows the input valid in the same cycle.

Top module: `alu_fsa`

## Requirements
- R1: Opcode 0 gives a + b and opcode 1 gives a - b, both over all 64 bits with wrap-around.
- R2: Opcode 2 (word add) and opcode 3 (word subtract) work on bits [31:0] and sign-extend the 32-bit result to 64 bits.
- R3: Opcode 4 (signed less-than) and opcode 5 (unsigned less-than) return 1 or 0 in bit 0, and every other result bit is 0.
- R4: Opcodes 6, 7 and 8 shift the full 64-bit a left, logically right and arithmetically right by b[5:0]; the higher bits of b are ignored.
- R5: Opcodes 9, 10 and 11 shift a[31:0] left, logically right and arithmetically right by b[4:0], then sign-extend the 32-bit result to 64 bits.
- R6: Opcode 12 returns the sign extension of (b[31:0] + (a[31:0] >> 31)) mod 2^32.
- R7: For opcode 12, a[30:0], a[63:32] and b[63:32] have no effect on the result.
- R8: The result is a combinational function of the current operator and operands, with no dependence on earlier inputs.
- R9: in_ready_o is always 1, and out_valid_o equals in_valid_i in the same cycle.
- R10: Opcodes 13, 14 and 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operator code |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B (also carries the shift amount) |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Unit can accept a request |
| result_o | output | 64 | Operation result |
| out_valid_o | output | 1 | Result is valid |

## Verification
Every result and the output valid are due in the same cycle the inputs are applied, with zero registers on the path. The bench drives each request just after a rising clock edge. It compares the outputs at the following falling edge, half a period later, when the combinational paths have settled. Back-to-back requests with different operators are applied so that any stale value from the previous request would show up as a mismatch.

// File: rtl/alu_fsa_pkg.sv
package alu_fsa_pkg;
  parameter int XLEN = 64;
  parameter int WLEN = 32;
  parameter int FUSE_SHAMT = 31;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDW  = 4'd2,
    OP_SUBW  = 4'd3,
    OP_SLT   = 4'd4,
    OP_SLTU  = 4'd5,
    OP_SLL   = 4'd6,
    OP_SRL   = 4'd7,
    OP_SRA   = 4'd8,
    OP_SLLW  = 4'd9,
    OP_SRLW  = 4'd10,
    OP_SRAW  = 4'd11,
    OP_SRADW = 4'd12
  } alu_op_e;

  // widen a word to full width, copying the word's top bit
  function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] w);
    return {{(XLEN-WLEN){w[WLEN-1]}}, w};
  endfunction

  // signed less-than from operand signs and the difference's top bit
  function automatic logic signed_lt(input logic sa, input logic sb, input logic sd);
    return (sa != sb) ? sa : sd;
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   ext;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign ext    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o  = ext[W-1:0];
  // with subtraction, carry-out set means a >= b unsigned
  assign lt_u_o = ~ext[W];
  assign lt_s_o = alu_fsa_pkg::signed_lt(a_i[W-1], b_i[W-1], ext[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W   = 64,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] shamt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0]        rin;
  logic [W-1:0]        rout;
  logic [W-1:0]        x;
  logic [W-1:0]        shr;
  logic                fill;
  logic signed [W:0]   ext;

  // a left shift is a right shift of the bit-reversed word
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rin[i]  = data_i[W-1-i];
    assign rout[i] = shr[W-1-i];
  end

  assign x     = left_i ? rin : data_i;
  assign fill  = arith_i & ~left_i & data_i[W-1];
  assign ext   = {fill, x};
  assign shr   = W'(ext >>> shamt_i);
  assign res_o = left_i ? rout : shr;
endmodule

// File: rtl/alu_fused.sv
module alu_fused #(
  parameter int WW    = 32,
  parameter int SHAMT = 31
) (
  input  logic [WW-1:0] a_w_i,
  input  logic [WW-1:0] b_w_i,
  output logic [WW-1:0] shifted_o,
  output logic [WW-1:0] sum_o
);
  assign shifted_o = a_w_i >> SHAMT;
  assign sum_o     = shifted_o + b_w_i;
endmodule

// File: rtl/alu_fsa.sv
module alu_fsa
  import alu_fsa_pkg::*;
(
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  output logic [XLEN-1:0] result_o,
  output logic            out_valid_o
);
  localparam int SW64 = $clog2(XLEN);
  localparam int SW32 = $clog2(WLEN);

  alu_op_e        op;
  logic           sub_sel;
  logic [XLEN-1:0] sum_full;
  logic           lt_s;
  logic           lt_u;
  logic [XLEN-1:0] shift_full;
  logic [WLEN-1:0] shift_word;
  logic [WLEN-1:0] fused_shift;
  logic [WLEN-1:0] fused_sum;

  assign op      = alu_op_e'(op_i);
  assign sub_sel = (op == OP_SUB) || (op == OP_SUBW) || (op == OP_SLT) || (op == OP_SLTU);

  alu_addsub #(.W(XLEN)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_sel),
    .sum_o  (sum_full),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_shifter #(.W(XLEN)) u_shift_full (
    .data_i  (a_i),
    .shamt_i (b_i[SW64-1:0]),
    .left_i  (op == OP_SLL),
    .arith_i (op == OP_SRA),
    .res_o   (shift_full)
  );

  alu_shifter #(.W(WLEN)) u_shift_word (
    .data_i  (a_i[WLEN-1:0]),
    .shamt_i (b_i[SW32-1:0]),
    .left_i  (op == OP_SLLW),
    .arith_i (op == OP_SRAW),
    .res_o   (shift_word)
  );

  alu_fused #(.WW(WLEN), .SHAMT(FUSE_SHAMT)) u_fused (
    .a_w_i     (a_i[WLEN-1:0]),
    .b_w_i     (b_i[WLEN-1:0]),
    .shifted_o (fused_shift),
    .sum_o     (fused_sum)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:           result_o = sum_full;
      OP_ADDW, OP_SUBW:         result_o = sext_word(sum_full[WLEN-1:0]);
      OP_SLT:                   result_o = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU:                  result_o = {{(XLEN-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA:   result_o = shift_full;
      OP_SLLW, OP_SRLW, OP_SRAW: result_o = sext_word(shift_word);
      OP_SRADW:                 result_o = sext_word(fused_sum);
      default:                  result_o = '0;
    endcase
  end

  assign in_ready_o  = 1'b1;
  assign out_valid_o = in_valid_i;
endmodule

// File: rtl/alu_fsa_checker.sv
module alu_fsa_checker
  import alu_fsa_pkg::*;
(
  input logic [3:0]      op_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [XLEN-1:0] result_o,
  input logic            out_valid_o,
  input logic [WLEN-1:0] fused_shift
);
  logic [WLEN-1:0] fused_delta;
  assign fused_delta = result_o[WLEN-1:0] - b_i[WLEN-1:0];

  always_comb begin
    // R3: compares only ever set bit 0
    if (op_i == 4'd4 || op_i == 4'd5)
      a_r3_cmp_single_bit: assert (result_o[XLEN-1:1] == '0);
    // R2 / R5: word forms are sign-extended
    if (op_i == 4'd2 || op_i == 4'd3 || (op_i >= 4'd9 && op_i <= 4'd12))
      a_r2_word_sext: assert (result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}});
    // R6: fused result differs from b's low word by 0 or 1
    if (op_i == 4'd12)
      a_r6_fused_step: assert (fused_delta <= 1 && fused_shift <= 1);
    // R4: a zero shift leaves the operand intact
    if ((op_i >= 4'd6 && op_i <= 4'd8) && b_i[5:0] == 6'd0)
      a_r4_zero_shift: assert (result_o == a_i);
    // R10: undefined opcodes give zero
    if (op_i >= 4'd13)
      a_r10_unknown_zero: assert (result_o == '0);
    // R9: handshake passes straight through
    a_r9_handshake: assert (in_ready_o && (out_valid_o == in_valid_i));
  end
endmodule

bind alu_fsa alu_fsa_checker u_alu_fsa_checker (
  .op_i        (op_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .result_o    (result_o),
  .out_valid_o (out_valid_o),
  .fused_shift (fused_shift)
);

// File: tb/test_alu_fsa.sv
module test_alu_fsa;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [63:0] a, b;
  logic        vin;
  logic        rdy, vout;
  logic [63:0] res;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_fsa i_alu_fsa (
    .op_i(op), .a_i(a), .b_i(b), .in_valid_i(vin),
    .in_ready_o(rdy), .result_o(res), .out_valid_o(vout)
  );

  function automatic logic [63:0] wext(input logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y);
    logic [31:0] xw;
    xw = x[31:0];
    case (o)
      4'd0:  return x + y;
      4'd1:  return x + ~y + 64'd1;
      4'd2:  return wext(x + y);
      4'd3:  return wext(x - y);
      4'd4:  return ($signed(x) < $signed(y)) ? 64'd1 : 64'd0;
      4'd5:  return (x < y) ? 64'd1 : 64'd0;
      4'd6:  return x << y[5:0];
      4'd7:  return x >> y[5:0];
      4'd8:  return 64'($signed(x) >>> y[5:0]);
      4'd9:  return wext({32'd0, xw << y[4:0]});
      4'd10: return wext({32'd0, xw >> y[4:0]});
      4'd11: return wext({32'd0, 32'($signed(xw) >>> y[4:0])});
      4'd12: return wext({32'd0, y[31:0] + {31'd0, x[31]}});
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive after a rising edge, sample at the next falling edge
  task automatic run(input string tag, input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                     input logic [63:0] exp);
    @(posedge clk); #1;
    op = o; a = x; b = y; vin = 1'b1;
    @(negedge clk);
    check(tag, res, exp);
    check({tag, " model"}, res, model(o, x, y));
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R9 idle valid", {63'd0, vout}, 64'd0);
    check("R9 idle ready", {63'd0, rdy}, 64'd1);
  endtask

  task automatic t_arith;
    run("R1 add", 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1);
    run("R1 sub", 4'd1, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE);
    run("R2 addw ovf", 4'd2, 64'h0000_0000_7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000);
    run("R2 subw", 4'd3, 64'h1234_0000_0000_0005, 64'd6, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_cmp;
    run("R3 slt", 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd1);
    run("R3 sltu", 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0);
    run("R3 slt eq", 4'd4, 64'd7, 64'd7, 64'd0);
    run("R3 sltu lt", 4'd5, 64'd2, 64'h8000_0000_0000_0000, 64'd1);
  endtask

  task automatic t_shift;
    run("R4 sll hi b ignored", 4'd6, 64'd1, 64'hFF00_0000_0000_0043, 64'd8);
    run("R4 srl", 4'd7, 64'h8000_0000_0000_0000, 64'd63, 64'd1);
    run("R4 sra", 4'd8, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000);
    run("R5 sllw shamt b[4:0]", 4'd9, 64'h4000_0000, 64'd33, 64'hFFFF_FFFF_8000_0000);
    run("R5 srlw", 4'd10, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'h0000_0000_0800_0000);
    run("R5 sraw", 4'd11, 64'h0000_0000_8000_0000, 64'd4, 64'hFFFF_FFFF_F800_0000);
  endtask

  task automatic t_fused;
    run("R6 fused bit set", 4'd12, 64'h0000_0000_8000_0000, 64'd5, 64'd6);
    run("R6 fused bit clear", 4'd12, 64'h0000_0000_7FFF_FFFF, 64'd5, 64'd5);
    run("R6 fused sext", 4'd12, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_8000_0000);
    run("R6 fused wrap", 4'd12, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 64'd0);
    run("R7 fused upper a ignored", 4'd12, 64'hFFFF_FFFF_0000_0000, 64'hABCD_0000_0000_0009, 64'd9);
    run("R7 fused low a ignored", 4'd12, 64'h5555_5555_FFFF_FFFF, 64'h1111_1111_0000_0010, 64'd17);
  endtask

  task automatic t_misc;
    for (int k = 13; k < 16; k++)
      run("R10 unknown op", 4'(k), 64'hDEAD_BEEF_0000_0001, 64'd1, 64'd0);
    // R8: same request after a different one gives the same answer
    run("R8 repeat A", 4'd0, 64'd100, 64'd23, 64'd123);
    run("R8 interleave", 4'd8, 64'hFFFF_FFFF_FFFF_FF00, 64'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R8 repeat B", 4'd0, 64'd100, 64'd23, 64'd123);
    @(negedge clk);
    check("R9 valid follows", {63'd0, vout}, 64'd1);
    vin = 1'b0; #1;
    check("R9 valid drops", {63'd0, vout}, 64'd0);
    check("R9 ready held", {63'd0, rdy}, 64'd1);
  endtask

  initial begin
    op = 4'd0; a = '0; b = '0; vin = 1'b0;
    t_idle();
    t_arith();
    t_cmp();
    t_shift();
    t_fused();
    t_misc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule